// File: doc/BRIEF.md
# Dual Cascadable Decade/Binary Up Counter

This block holds a number of independent 4-bit up counters (two by default). A build-time mode chooses whether they count in decimal (0 to 9) or in plain binary (0 to 15). Each counter has two trigger lines. A count can be raised by a rising edge on one line while the other is high, or by a falling edge on the other line while the first is low. Because of this, counters can be chained on either edge polarity: the top stage of one counter drives a trigger line of the next. A high clear line forces a counter to zero.

All trigger and clear lines are asynchronous to the fabric clock. Each one passes through a two-flop synchronizer. Edges are found by comparing the newest synchronized sample with the one before it, and the level of the partner line is taken from that same sample. In decimal mode, the six unused codes have fixed successors, so a corrupted counter returns to the legal range within two counts.

Top module: `dual_cascade_counter`

## Requirements
- R1: While the synchronous system reset `rst` is high at a clock edge, every counter output becomes 0.
- R2: A 0-to-1 change on `ck_in` while `gate_in` is 1 (and clear low) adds exactly one count to that channel.
- R3: A 1-to-0 change on `gate_in` while `ck_in` is 0 (and clear low) adds exactly one count to that channel.
- R4: The value is unchanged after a falling `ck_in`, a rising `gate_in`, a rising `ck_in` while `gate_in` is 0, or a falling `gate_in` while `ck_in` is 1.
- R5: While `clr_in` is high, the channel output is 0 and trigger edges are ignored. A qualifying trigger edge that arrives in the same sample as the clear also leaves 0.
- R6: In decimal mode the sequence is 0,1,...,9, and the count after 9 is 0.
- R7: In binary mode the sequence is 0,1,...,15, and the count after 15 is 0.
- R8: In decimal mode the unused codes step as follows: an even code (10, 12, 14) goes to the code plus one, and an odd code (11, 13, 15) goes to 4. Any code therefore reaches 0..9 within two counts.
- R9: Each channel has its own `ck_in`, `gate_in`, `clr_in` bit and its own 4-bit output field `q_out[ch*4 +: 4]`. Activity on one channel never changes another channel.
- R10: An input change made between two system clock edges shows up on `q_out` right after the third following rising edge of `clk`, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all lines |
| rst | input | 1 | Synchronous active-high system reset |
| ck_in | input | NUM_CH | Rising-edge trigger line, one bit per channel |
| gate_in | input | NUM_CH | Falling-edge trigger line and qualifier, one bit per channel |
| clr_in | input | NUM_CH | Active-high clear, one bit per channel |
| q_out | output | NUM_CH*WIDTH | Counter values, channel ch in bits ch*WIDTH +: WIDTH |

## Verification
A clear and a qualifying trigger edge can reach the counter register in the same sample. The bench provokes this by raising `clr_in` and a valid `ck_in` edge at the same moment, so both cross the synchronizers together. The result is judged correct only if the output reads 0, and only if releasing the clear afterwards, with no new edge, produces no late count. Both trigger styles run on both channels. A decimal and a binary instance are driven in parallel, and the next-state logic is swept over all sixteen codes in both modes.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic {
    DCC_BINARY = 1'b0,
    DCC_DECADE = 1'b1
  } dcc_mode_e;

  typedef struct packed {
    logic ck;
    logic gate;
    logic clr;
  } dcc_lines_t;
endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  dcc_pkg::dcc_lines_t raw,
  output dcc_pkg::dcc_lines_t synced
);
  dcc_pkg::dcc_lines_t chain [STAGES];

  // No reset: the chain follows the pins during reset so release sees no false edge.
  always_ff @(posedge clk) begin
    chain[0] <= raw;
    for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
  end

  assign synced = chain[STAGES-1];
endmodule

// File: rtl/dcc_edge_qual.sv
module dcc_edge_qual (
  input  logic                clk,
  input  logic                rst,
  input  dcc_pkg::dcc_lines_t now_s,
  output logic                fire,
  output logic                clr_lvl
);
  logic prev_ck;
  logic prev_gate;

  always_ff @(posedge clk) begin
    prev_ck   <= now_s.ck;
    prev_gate <= now_s.gate;
  end

  logic ck_rise;
  logic gate_fall;
  assign ck_rise   = now_s.ck & ~prev_ck & now_s.gate;
  assign gate_fall = ~now_s.gate & prev_gate & ~now_s.ck;
  assign fire      = ck_rise | gate_fall;
  assign clr_lvl   = now_s.clr;

  // R2 R3: one transition yields one pulse only
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
  // R4: a falling trigger line with its partner idle never fires
  p_no_fire_ck_fall_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(now_s.ck) && $stable(now_s.gate)) |-> !fire);
endmodule

// File: rtl/dcc_step.sv
module dcc_step #(
  parameter int                WIDTH = 4,
  parameter dcc_pkg::dcc_mode_e MODE = dcc_pkg::DCC_DECADE
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] LAST    = (MODE == dcc_pkg::DCC_DECADE) ? WIDTH'(9) : '1;
  localparam logic [WIDTH-1:0] REENTRY = WIDTH'(4);

  generate
    if (MODE == dcc_pkg::DCC_DECADE) begin : g_decade
      always_comb begin
        if (cur == LAST)     nxt = '0;
        else if (cur > LAST) nxt = cur[0] ? REENTRY : cur + WIDTH'(1);
        else                 nxt = cur + WIDTH'(1);
      end
      // R8: legal codes never leave the legal range
      always_comb begin
        if (cur <= LAST) a_legal_closed_r8: assert (nxt <= LAST);
      end
    end else begin : g_binary
      always_comb nxt = cur + WIDTH'(1);
    end
  endgenerate
endmodule

// File: rtl/dcc_counter.sv
module dcc_counter #(
  parameter int                WIDTH = 4,
  parameter dcc_pkg::dcc_mode_e MODE = dcc_pkg::DCC_DECADE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             clr,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] LAST = (MODE == dcc_pkg::DCC_DECADE) ? WIDTH'(9) : '1;

  logic [WIDTH-1:0] q_next;

  dcc_step #(.WIDTH(WIDTH), .MODE(MODE)) u_step (
    .cur (q),
    .nxt (q_next)
  );

  always_ff @(posedge clk) begin
    if (rst || clr)  q <= '0;
    else if (fire)   q <= q_next;
  end

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !fire) |=> $stable(q));
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (fire && !clr && q == LAST) |=> (q == '0));
  p_increment_r2: assert property (@(posedge clk) disable iff (rst)
    (fire && !clr && q < LAST) |=> (q == $past(q) + WIDTH'(1)));

  generate
    if (MODE == dcc_pkg::DCC_DECADE) begin : g_range
      p_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        q <= LAST);
    end
  endgenerate
endmodule

// File: rtl/dcc_channel.sv
module dcc_channel #(
  parameter int                WIDTH     = 4,
  parameter int                SYNC_LEN  = 2,
  parameter dcc_pkg::dcc_mode_e MODE     = dcc_pkg::DCC_DECADE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ck,
  input  logic             gate,
  input  logic             clr,
  output logic [WIDTH-1:0] q
);
  dcc_pkg::dcc_lines_t raw_lines;
  dcc_pkg::dcc_lines_t sync_lines;
  logic                fire;
  logic                clr_lvl;

  assign raw_lines = '{ck: ck, gate: gate, clr: clr};

  dcc_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk    (clk),
    .raw    (raw_lines),
    .synced (sync_lines)
  );

  dcc_edge_qual u_qual (
    .clk     (clk),
    .rst     (rst),
    .now_s   (sync_lines),
    .fire    (fire),
    .clr_lvl (clr_lvl)
  );

  dcc_counter #(.WIDTH(WIDTH), .MODE(MODE)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .fire (fire),
    .clr  (clr_lvl),
    .q    (q)
  );
endmodule

// File: rtl/dual_cascade_counter.sv
module dual_cascade_counter #(
  parameter int                NUM_CH   = 2,
  parameter int                WIDTH    = 4,
  parameter int                SYNC_LEN = 2,
  parameter dcc_pkg::dcc_mode_e MODE    = dcc_pkg::DCC_DECADE
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       ck_in,
  input  logic [NUM_CH-1:0]       gate_in,
  input  logic [NUM_CH-1:0]       clr_in,
  output logic [NUM_CH*WIDTH-1:0] q_out
);
  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [WIDTH-1:0] q_ch;

      dcc_channel #(.WIDTH(WIDTH), .SYNC_LEN(SYNC_LEN), .MODE(MODE)) u_chan (
        .clk  (clk),
        .rst  (rst),
        .ck   (ck_in[ch]),
        .gate (gate_in[ch]),
        .clr  (clr_in[ch]),
        .q    (q_ch)
      );

      assign q_out[ch*WIDTH +: WIDTH] = q_ch;

      // R1: reset clears each channel
      p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (q_ch == '0));
    end
  endgenerate
endmodule

// File: tb/dual_cascade_counter_bench.sv
module dual_cascade_counter_bench;
  localparam int NCH = 2;
  localparam int W   = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] ck  = '0;
  logic [NCH-1:0] gt  = '0;
  logic [NCH-1:0] cl  = '0;
  logic [NCH*W-1:0] q_dec;
  logic [NCH*W-1:0] q_bin;
  logic [W-1:0] s_cur = '0;
  logic [W-1:0] s_dec;
  logic [W-1:0] s_bin;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int exp_d [NCH];
  int exp_b [NCH];

  always #2 clk = ~clk;

  dual_cascade_counter #(.NUM_CH(NCH), .WIDTH(W), .MODE(dcc_pkg::DCC_DECADE)) u_dual_cascade_counter (
    .clk(clk), .rst(rst), .ck_in(ck), .gate_in(gt), .clr_in(cl), .q_out(q_dec));

  dual_cascade_counter #(.NUM_CH(NCH), .WIDTH(W), .MODE(dcc_pkg::DCC_BINARY)) u_dual_cascade_counter_bin (
    .clk(clk), .rst(rst), .ck_in(ck), .gate_in(gt), .clr_in(cl), .q_out(q_bin));

  dcc_step #(.WIDTH(W), .MODE(dcc_pkg::DCC_DECADE)) u_step_dec (.cur(s_cur), .nxt(s_dec));
  dcc_step #(.WIDTH(W), .MODE(dcc_pkg::DCC_BINARY)) u_step_bin (.cur(s_cur), .nxt(s_bin));

  function automatic int dec_next(int c);
    if (c == 9) return 0;
    if (c > 9)  return (c % 2 == 1) ? 4 : c + 1;
    return c + 1;
  endfunction

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic check_all(int ch, string tag);
    for (int c = 0; c < NCH; c++) begin
      chk((c == ch) ? {tag, " dec"} : "R9 dec", int'(q_dec[c*W +: W]), exp_d[c]);
      chk((c == ch) ? {tag, " bin"} : "R9 bin", int'(q_bin[c*W +: W]), exp_b[c]);
    end
  endtask

  // Drive one channel at a negedge, update the model, wait out the latency, check.
  task automatic drive(int ch, logic nc, logic ng, logic nl, string tag);
    logic oc;
    logic og;
    bit   cnt;
    oc  = ck[ch];
    og  = gt[ch];
    cnt = (nc && !oc && ng) || (!ng && og && !nc);
    ck[ch] = nc;
    gt[ch] = ng;
    cl[ch] = nl;
    if (nl) begin
      exp_d[ch] = 0;
      exp_b[ch] = 0;
    end else if (cnt) begin
      exp_d[ch] = dec_next(exp_d[ch]);
      exp_b[ch] = (exp_b[ch] + 1) % 16;
    end
    repeat (4) @(negedge clk);
    check_all(ch, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin exp_d[c] = 0; exp_b[c] = 0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_all(0, "R1");

    // R2 R6: rising ck_in with gate high, decimal wrap after 9
    drive(0, 1'b0, 1'b1, 1'b0, "R4 gate rise");
    for (int i = 0; i < 12; i++) begin
      drive(0, 1'b1, 1'b1, 1'b0, "R2 R6 R7");
      drive(0, 1'b0, 1'b1, 1'b0, "R4 ck fall");
    end

    // R3 R7: falling gate_in with ck low, binary wrap after 15
    drive(1, 1'b0, 1'b1, 1'b0, "R4 gate rise");
    for (int i = 0; i < 18; i++) begin
      drive(1, 1'b0, 1'b0, 1'b0, "R3 R6 R7");
      drive(1, 1'b0, 1'b1, 1'b0, "R4 gate rise");
    end

    // R4: non-counting transitions
    drive(0, 1'b0, 1'b0, 1'b0, "R3");
    drive(0, 1'b1, 1'b0, 1'b0, "R4 ck rise gate low");
    drive(0, 1'b1, 1'b1, 1'b0, "R4 gate rise ck high");
    drive(0, 1'b1, 1'b0, 1'b0, "R4 gate fall ck high");
    drive(0, 1'b0, 1'b0, 1'b0, "R4 ck fall");

    // R5: clear dominates, same-sample clear and edge
    drive(0, 1'b0, 1'b0, 1'b1, "R5 clear");
    drive(0, 1'b1, 1'b1, 1'b1, "R5 edge under clear");
    drive(0, 1'b0, 1'b1, 1'b1, "R5 hold");
    drive(0, 1'b0, 1'b1, 1'b0, "R5 release");
    drive(0, 1'b1, 1'b1, 1'b1, "R5 same sample");
    drive(0, 1'b1, 1'b1, 1'b0, "R5 no late count");
    drive(0, 1'b0, 1'b1, 1'b0, "R4 ck fall");
    drive(0, 1'b1, 1'b1, 1'b0, "R5 resume");
    drive(0, 1'b0, 1'b1, 1'b0, "R4 ck fall");

    // R10: output moves after the third rising edge, not the second
    ck[0] = 1'b1;
    repeat (2) @(negedge clk);
    check_all(0, "R10 early");
    @(negedge clk);
    exp_d[0] = dec_next(exp_d[0]);
    exp_b[0] = (exp_b[0] + 1) % 16;
    check_all(0, "R10 on time");
    drive(0, 1'b0, 1'b1, 1'b0, "R4 ck fall");

    // R1: reset in mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin exp_d[c] = 0; exp_b[c] = 0; end
    check_all(0, "R1 mid-run");
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check_all(0, "R1 after release");

    // R6 R7 R8: next-state sweep over every code
    for (int c = 0; c < 16; c++) begin
      s_cur = W'(c);
      #1;
      chk("R6 R8 step dec", int'(s_dec), dec_next(c));
      chk("R7 step bin", int'(s_bin), (c + 1) % 16);
      s_cur = s_dec;
      #1;
      chk("R8 two-count bound", int'(s_dec <= W'(9)), 1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule